// File: doc/BRIEF.md
# Indexed Register Port Slave

This block is the device side of a narrow host port that reaches a 128-entry register space through only two host-visible locations. A select input chooses which one an access touches: with select low, a write loads a pointer register with the register number; with select high, a read or write is steered to whichever register that pointer names. The host therefore always makes two accesses: the first sets the pointer and the second moves the data. Every access is gated by a chip-select input and qualified by separate read and write strobes.

Behind the pointer are a control register, an interrupt enable register, an interrupt source register and a soft-reset trigger. The control register holds a two-bit bit-rate mode. A small bank of general-purpose storage words is also mapped into the space. A write to the soft-reset trigger clears the interrupt and control state and starts an internal counter. When the counter expires, the ready bit of the interrupt source register is set, standing in for a device that needs some time to become ready. The interrupt line is raised whenever an enabled source bit is pending. Reading the source register returns its contents and clears it in the same access.

Top module: `idxport_slave`

## Requirements
- R1: A write with `host_cs`=1 and `host_sel`=0 loads the pointer with `host_wdata[6:0]`, so pointer values wrap modulo 128. A read with `host_sel`=0 returns the pointer zero-extended to 16 bits.
- R2: Pointer values 0x10 to 0x1F select 16 storage words. A data-port write to one of them stores all 16 bits, and a data-port read returns the stored word.
- R3: Data-port reads of unimplemented pointer values, and of the write-only trigger at 0x0B, return 0. Data-port writes to unimplemented values and to the read-only source register at 0x0E are ignored.
- R4: Read and write strobes have no effect while `host_cs` is 0.
- R5: A data-port write of any value to pointer 0x0B clears the enable register, the source register and the control register, which returns `rate_mode` to 0. The storage words keep their contents.
- R6: Bit 6 of the source register (the ready bit) becomes 1 exactly RDY_DELAY clock edges after the edge that took the soft-reset write. A new soft reset before that point restarts the count.
- R7: A data-port read of pointer 0x0E returns the source register as it was before the read, and the register is cleared at that same edge. A ready event arriving at the same edge still sets its bit.
- R8: `irq` is 1 exactly when the source register ANDed with the enable register (pointer 0x0C, 8 bits) is non-zero. It changes at the same edge as those registers.
- R9: The control register (pointer 0x08, 16 bits) drives `rate_mode` from its bits [2:1]: 0 selects constant rate, 1 selects maximum rate and 3 selects variable rate. A write carrying code 2 leaves bits [2:1] unchanged, and all other bits are stored as written.
- R10: Read data appears on `host_rdata` after the edge that takes the read strobe. It holds until the next read.
- R11: After a synchronous reset, the pointer, the enable, source and control registers, `host_rdata`, `irq` and `rate_mode` are all 0, and no ready count is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs | input | 1 | Chip select, qualifies both strobes |
| host_sel | input | 1 | 0 selects the pointer location, 1 selects the data location |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data, valid after the read edge |
| irq | output | 1 | Interrupt request, OR of enabled pending sources |
| rate_mode | output | 2 | Current bit-rate mode from control bits [2:1] |

## Verification
The assertions check, on every cycle, the properties that hold locally:
- the pointer load after an index write;
- that nothing changes without chip select;
- that state is cleared after a soft reset;
- the exact masking relation behind `irq`;
- that `rate_mode` never holds the reserved code and is untouched by a code-2 write.

The bench's scenarios cover the behaviours that need a history of accesses:
- the exact cycle on which the ready bit appears after a soft reset;
- clear-on-read, together with the value it returns;
- read-back of every pointer value and every storage word;
- zero reads across the whole unimplemented range;
- that storage survives a soft reset.

// File: rtl/idxport_pkg.sv
package idxport_pkg;
  // Register slots decoded from the pointer; order matches REG_IDX below.
  typedef enum int {
    SLOT_CTRL = 0,
    SLOT_SRST = 1,
    SLOT_IEN  = 2,
    SLOT_ISRC = 3
  } slot_e;

  localparam int NREG = 4;
  localparam int REG_IDX [NREG] = '{8'h08, 8'h0B, 8'h0C, 8'h0E};

  // Bit-rate codes held in control bits [2:1].
  typedef enum logic [1:0] {
    RATE_CONST = 2'd0,
    RATE_MAX   = 2'd1,
    RATE_RSVD  = 2'd2,
    RATE_VAR   = 2'd3
  } rate_e;

  localparam int RATE_LSB = 1;
  localparam int RDY_BIT  = 6;
endpackage

// File: rtl/idxport_decode.sv
module idxport_decode
  import idxport_pkg::*;
#(
  parameter int IDX_W     = 7,
  parameter int SCR_BASE  = 16,
  parameter int SCR_DEPTH = 16,
  parameter int SA_W      = 4
) (
  input  logic [IDX_W-1:0] idx,
  output logic [NREG-1:0]  hit,
  output logic             hit_scr,
  output logic [SA_W-1:0]  scr_addr
);
  // One comparator per named register slot.
  for (genvar g = 0; g < NREG; g++) begin : g_slot
    assign hit[g] = (idx == IDX_W'(REG_IDX[g]));
  end

  // Storage window: base and depth are parameters.
  always_comb begin
    int ii;
    ii       = int'(idx);
    hit_scr  = (ii >= SCR_BASE) && (ii < SCR_BASE + SCR_DEPTH);
    scr_addr = SA_W'(ii - SCR_BASE);
  end
endmodule

// File: rtl/idxport_scratch.sv
module idxport_scratch #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int SA_W   = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [SA_W-1:0]   addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  // Single-port array, registered read, no reset, so block RAM can be inferred.
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) q <= mem[addr];
  end
endmodule

// File: rtl/idxport_rdy_timer.sv
module idxport_rdy_timer #(
  parameter int DELAY = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic fire
);
  localparam int CW = $clog2(DELAY + 1);

  logic [CW-1:0] cnt;
  logic          busy;

  // start at edge E0 -> fire high between E(DELAY-1) and E(DELAY).
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(DELAY - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign fire = busy && (cnt == '0);
endmodule

// File: rtl/idxport_slave.sv
module idxport_slave
  import idxport_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int IDX_W     = 7,
  parameter int SRC_W     = 8,
  parameter int SCR_BASE  = 16,
  parameter int SCR_DEPTH = 16,
  parameter int RDY_DELAY = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_cs,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq,
  output logic [1:0]        rate_mode
);
  localparam int SA_W = (SCR_DEPTH > 1) ? $clog2(SCR_DEPTH) : 1;

  logic [IDX_W-1:0]  idx_q;
  logic [SRC_W-1:0]  ien_q, isrc_q, ien_n, isrc_n;
  logic [DATA_W-1:0] ctrl_q, ctrl_n;
  logic [DATA_W-1:0] rdat_q, reg_val;
  logic              scr_sel_q;
  logic [NREG-1:0]   hit;
  logic              hit_scr, fire;
  logic [SA_W-1:0]   scr_addr;
  logic [DATA_W-1:0] scr_q;

  // Qualified strobes.
  logic acc_wr, acc_rd, dwr, drd, srst;
  assign acc_wr = host_cs & host_wr;
  assign acc_rd = host_cs & host_rd;
  assign dwr    = acc_wr & host_sel;
  assign drd    = acc_rd & host_sel;
  assign srst   = dwr & hit[SLOT_SRST];

  idxport_decode #(
    .IDX_W(IDX_W), .SCR_BASE(SCR_BASE), .SCR_DEPTH(SCR_DEPTH), .SA_W(SA_W)
  ) u_dec (
    .idx(idx_q), .hit(hit), .hit_scr(hit_scr), .scr_addr(scr_addr)
  );

  idxport_scratch #(
    .DATA_W(DATA_W), .DEPTH(SCR_DEPTH), .SA_W(SA_W)
  ) u_scr (
    .clk(clk), .we(dwr & hit_scr), .re(drd & hit_scr),
    .addr(scr_addr), .wdata(host_wdata), .q(scr_q)
  );

  idxport_rdy_timer #(.DELAY(RDY_DELAY)) u_tmr (
    .clk(clk), .rst(rst), .start(srst), .fire(fire)
  );

  // Next-state for the interrupt and control registers.
  always_comb begin
    ien_n = ien_q;
    if (dwr && hit[SLOT_IEN]) ien_n = host_wdata[SRC_W-1:0];
    if (srst) ien_n = '0;

    isrc_n = isrc_q;
    if (drd && hit[SLOT_ISRC]) isrc_n = '0;   // clear on read
    if (fire) isrc_n[RDY_BIT] = 1'b1;         // a new event beats the clear
    if (srst) isrc_n = '0;                    // a restart beats a stale event

    ctrl_n = ctrl_q;
    if (dwr && hit[SLOT_CTRL]) begin
      ctrl_n = host_wdata;
      if (rate_e'(host_wdata[RATE_LSB +: 2]) == RATE_RSVD)
        ctrl_n[RATE_LSB +: 2] = ctrl_q[RATE_LSB +: 2];
    end
    if (srst) ctrl_n = '0;
  end

  // Data-port read value for the non-storage registers.
  always_comb begin
    reg_val = '0;
    if (hit[SLOT_CTRL]) reg_val = ctrl_q;
    if (hit[SLOT_IEN])  reg_val = DATA_W'(ien_q);
    if (hit[SLOT_ISRC]) reg_val = DATA_W'(isrc_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q     <= '0;
      ien_q     <= '0;
      isrc_q    <= '0;
      ctrl_q    <= '0;
      irq       <= 1'b0;
      rdat_q    <= '0;
      scr_sel_q <= 1'b0;
    end else begin
      if (acc_wr && !host_sel) idx_q <= host_wdata[IDX_W-1:0];
      ien_q  <= ien_n;
      isrc_q <= isrc_n;
      ctrl_q <= ctrl_n;
      irq    <= |(isrc_n & ien_n);
      if (acc_rd) begin
        rdat_q    <= host_sel ? reg_val : DATA_W'(idx_q);
        scr_sel_q <= host_sel & hit_scr;
      end
    end
  end

  assign host_rdata = scr_sel_q ? scr_q : rdat_q;
  assign rate_mode  = ctrl_q[RATE_LSB +: 2];
endmodule

// File: rtl/idxport_checker.sv
module idxport_checker #(
  parameter int IDX_W = 7,
  parameter int SRC_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             host_cs,
  input logic             host_sel,
  input logic             host_wr,
  input logic [15:0]      host_wdata,
  input logic [IDX_W-1:0] idx_q,
  input logic [SRC_W-1:0] en_q,
  input logic [SRC_W-1:0] src_q,
  input logic             irq,
  input logic [1:0]       rate_mode
);
  a_r1_index_load: assert property (@(posedge clk) disable iff (rst)
    (host_cs && host_wr && !host_sel) |=> (idx_q == $past(host_wdata[IDX_W-1:0])));

  a_r4_no_cs_hold: assert property (@(posedge clk) disable iff (rst)
    (!host_cs) |=> ($stable(idx_q) && $stable(en_q) && $stable(rate_mode)));

  a_r5_srst_clear: assert property (@(posedge clk) disable iff (rst)
    (host_cs && host_wr && host_sel && idx_q == IDX_W'(8'h0B))
      |=> (en_q == '0 && src_q == '0 && rate_mode == 2'd0));

  a_r8_irq_mask: assert property (@(posedge clk) disable iff (rst)
    irq == |(src_q & en_q));

  a_r9_no_rsvd: assert property (@(posedge clk) disable iff (rst)
    rate_mode != 2'd2);

  a_r9_rsvd_hold: assert property (@(posedge clk) disable iff (rst)
    (host_cs && host_wr && host_sel && idx_q == IDX_W'(8'h08) && host_wdata[2:1] == 2'd2)
      |=> (rate_mode == $past(rate_mode)));
endmodule

bind idxport_slave idxport_checker #(.IDX_W(IDX_W), .SRC_W(SRC_W)) u_chk (
  .clk(clk), .rst(rst), .host_cs(host_cs), .host_sel(host_sel),
  .host_wr(host_wr), .host_wdata(host_wdata), .idx_q(idx_q),
  .en_q(ien_q), .src_q(isrc_q), .irq(irq), .rate_mode(rate_mode)
);

// File: tb/idxport_slave_bench.sv
module idxport_slave_bench;
  localparam int D = 6;  // ready delay used in this bench

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_cs = 0, host_sel = 0, host_wr = 0, host_rd = 0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        irq;
  logic [1:0]  rate_mode;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  idxport_slave #(.RDY_DELAY(D)) u_idxport_slave (
    .clk(clk), .rst(rst), .host_cs(host_cs), .host_sel(host_sel),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq(irq), .rate_mode(rate_mode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Each access starts at a negedge and returns at the next negedge.
  task automatic wr(input logic sel, input logic [15:0] d, input logic cs);
    host_cs = cs; host_sel = sel; host_wr = 1'b1; host_wdata = d;
    @(negedge clk);
    host_cs = 1'b0; host_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, input logic cs, output logic [15:0] d);
    host_cs = cs; host_sel = sel; host_rd = 1'b1;
    @(negedge clk);
    d = host_rdata;
    host_cs = 1'b0; host_rd = 1'b0;
  endtask

  task automatic rd_reg(input logic [6:0] ix, output logic [15:0] d);
    wr(1'b0, {9'd0, ix}, 1'b1);
    rd(1'b1, 1'b1, d);
  endtask

  task automatic wr_reg(input logic [6:0] ix, input logic [15:0] v);
    wr(1'b0, {9'd0, ix}, 1'b1);
    wr(1'b1, v, 1'b1);
  endtask

  function automatic logic [15:0] pat(input int k);
    return 16'(k * 16'h0101) ^ 16'hA5C3;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [1:0]  mode;
    logic [15:0] ctrl;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    chk("R11 rdata", host_rdata, 0);
    chk("R11 irq", irq, 0);
    chk("R11 rate_mode", rate_mode, 0);
    rd(1'b0, 1'b1, d);
    chk("R11 pointer", d, 0);

    // R1 pointer sweep including wrap above 127
    for (int i = 0; i < 256; i++) begin
      wr(1'b0, 16'((i << 8) | i), 1'b1);
      rd(1'b0, 1'b1, d);
      chk("R1 pointer readback", d, i % 128);
    end

    // R2 storage words
    for (int k = 0; k < 16; k++) wr_reg(7'(16 + k), pat(k));
    for (int k = 0; k < 16; k++) begin
      rd_reg(7'(16 + k), d);
      chk("R2 storage readback", d, pat(k));
    end

    // R10 read data held over idle cycles
    @(negedge clk); @(negedge clk);
    chk("R10 hold after storage read", host_rdata, pat(15));
    rd_reg(7'h0C, d);
    @(negedge clk);
    chk("R10 hold after register read", host_rdata, 0);

    // R3 unimplemented indices read zero and ignore writes
    for (int i = 0; i < 128; i++) begin
      if (i == 8 || i == 11 || i == 12 || i == 14 || (i >= 16 && i < 32)) continue;
      wr_reg(7'(i), 16'hFFFF);
      rd_reg(7'(i), d);
      chk("R3 unimplemented reads zero", d, 0);
    end
    rd_reg(7'h0B, d);
    chk("R3 trigger reads zero", d, 0);

    // R4 chip select gating
    wr(1'b0, 16'h0021, 1'b1);
    rd(1'b0, 1'b1, d);
    wr(1'b0, 16'h0055, 1'b0);
    rd(1'b0, 1'b0, d);
    chk("R4 read without cs keeps rdata", d, 16'h0021);
    rd(1'b0, 1'b1, d);
    chk("R4 write without cs keeps pointer", d, 16'h0021);
    wr_reg(7'h10, pat(3));
    wr(1'b0, 16'h0010, 1'b1);
    wr(1'b1, 16'h1234, 1'b0);
    rd(1'b1, 1'b1, d);
    chk("R4 data write without cs ignored", d, pat(3));

    // R9 rate-mode field, code 2 keeps the previous value
    mode = 2'd0;
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 4; r++) begin
        ctrl = (16'hA5F0 ^ 16'(r << 12)) | 16'(((c + r) % 4) << 1);
        wr_reg(7'h08, ctrl);
        if (((c + r) % 4) != 2) mode = 2'((c + r) % 4);
        chk("R9 rate_mode", rate_mode, mode);
        rd_reg(7'h08, d);
        chk("R9 control readback", d, {ctrl[15:3], mode, ctrl[0]});
      end
    end

    // R5/R6/R8 soft reset, ready timing and interrupt
    wr_reg(7'h0C, 16'h00FF);
    wr(1'b0, 16'h000B, 1'b1);
    wr(1'b1, 16'hBEEF, 1'b1);           // edge E0
    chk("R5 rate cleared", rate_mode, 0);
    wr(1'b0, 16'h000C, 1'b1);           // E1
    wr(1'b1, 16'h0040, 1'b1);           // E2
    for (int n = 0; n < D - 3; n++) @(negedge clk);
    chk("R6 not ready one edge early", irq, 0);
    @(negedge clk);
    chk("R6 ready at delay", irq, 1);
    rd_reg(7'h08, d);
    chk("R5 control cleared", d, 0);
    rd_reg(7'h10, d);
    chk("R5 storage kept", d, pat(3));

    // R7 clear on read
    rd_reg(7'h0E, d);
    chk("R7 source value", d, 16'h0040);
    chk("R8 irq drops after clear", irq, 0);
    rd(1'b1, 1'b1, d);
    chk("R7 source cleared", d, 0);
    wr(1'b1, 16'hFFFF, 1'b1);
    rd(1'b1, 1'b1, d);
    chk("R3 source ignores writes", d, 0);

    // R8 masking and R5 enable clear
    wr(1'b0, 16'h000B, 1'b1);
    wr(1'b1, 16'h0000, 1'b1);
    rd_reg(7'h0C, d);
    chk("R5 enable cleared", d, 0);
    for (int n = 0; n < D + 2; n++) @(negedge clk);
    chk("R8 masked source no irq", irq, 0);
    wr_reg(7'h0C, 16'h00BF);
    chk("R8 other bits enabled no irq", irq, 0);
    wr(1'b1, 16'h0040, 1'b1);
    chk("R8 unmask raises irq", irq, 1);
    wr(1'b1, 16'h0000, 1'b1);
    chk("R8 mask drops irq", irq, 0);

    // R6 restart: second soft reset delays ready
    wr_reg(7'h0C, 16'h0040);
    rd_reg(7'h0E, d);
    wr(1'b0, 16'h000B, 1'b1);
    wr(1'b1, 16'h0001, 1'b1);           // E0
    @(negedge clk); @(negedge clk);     // E1, E2
    wr(1'b1, 16'h0002, 1'b1);           // restart at E3, enable cleared
    wr(1'b0, 16'h000C, 1'b1);
    wr(1'b1, 16'h0040, 1'b1);
    for (int n = 0; n < D - 3; n++) @(negedge clk);
    chk("R6 restart not early", irq, 0);
    @(negedge clk);
    chk("R6 restart ready", irq, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule